// File: doc/BRIEF.md
# Cyclic Channel-Group Scan Sequencer

This block runs an external successive-approximation converter through an endless scan of a channel group. It holds a small control word: run bit, group-select bit, two-bit channel-count field and interrupt enable. It issues one-cycle start requests with a channel number, takes the converter's done pulse and result, and keeps four result registers. Software sets or clears the run bit with a control write. An external trigger pulse can also set it.

The group bit picks the base channel: 0 or 4 with the default parameters. The count field holds the number of channels minus one. Each pass converts the base channel and the channels after it. When the last channel of a pass finishes, an end-of-scan flag is set, the interrupt line follows if enabled, and the scan starts again at the base channel. Clearing the run bit abandons the conversion in flight. Setting it again always resumes at the base channel.

The controller is a three-state machine. ST_IDLE goes to ST_ISSUE when the run bit is 1. ST_ISSUE raises the converter start for one cycle and moves to ST_BUSY, or back to ST_IDLE if the run bit has dropped. ST_BUSY goes to ST_IDLE when the run bit is 0. Otherwise it goes back to ST_ISSUE on an accepted done pulse, and waits there if no done pulse arrives.

Top module: `scan_seq`

## Requirements
- R1: After reset, conv_start, scan_run, eos_flag, irq and every result register are 0.
- R2: A control write with wr_run=1, or a trig pulse while stopped, sets scan_run. conv_start is then 1 in the second cycle after the cycle of that write or pulse.
- R3: The first conversion of every pass uses channel wr_grp*4, encoded as conv_chan = {group bit, position}.
- R4: A count field value n scans n+1 consecutive channels, from position 0 to position n, and then wraps to position 0.
- R5: conv_start is high for exactly one cycle per conversion. It rises in the cycle right after an accepted conv_done.
- R6: The result of the conversion at pass position k is stored in res_flat[k*DW +: DW] and is visible in the cycle after conv_done.
- R7: eos_flag becomes 1 in the cycle after the last position of a pass completes. With count 0 this happens after every conversion.
- R8: eos_flag stays 1 until a flag_clr pulse. If a pass completes in the same cycle as a clear, the flag ends up set.
- R9: irq equals eos_flag AND the latched interrupt enable.
- R10: A control write with wr_run=0 stops the scan. No further conv_start follows. A conv_done arriving after the stop changes no result register and not the flag.
- R11: A start after a stop begins at the base channel of the group written in the same control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| wr_run | input | 1 | Run bit value for the write |
| wr_grp | input | 1 | Group select value for the write |
| wr_cnt | input | 2 | Channel count minus one for the write |
| wr_ie | input | 1 | Interrupt enable value for the write |
| flag_clr | input | 1 | Clears the end-of-scan flag |
| trig | input | 1 | External start pulse |
| conv_done | input | 1 | Converter finished pulse |
| conv_data | input | DW | Converter result |
| conv_start | output | 1 | One-cycle converter start |
| conv_chan | output | 3 | Channel to convert |
| scan_run | output | 1 | Current run bit |
| eos_flag | output | 1 | End-of-scan flag |
| irq | output | 1 | Interrupt request |
| res_flat | output | 4*DW | Result registers, position 0 in the low bits |

## Verification
The bench builds the block with DW=10 and SLOTS=4. With these values both groups, all eight channel numbers and all four count values can be reached. The bench picks converter latencies from zero to three extra busy cycles, so the back-to-back start is checked after both immediate and delayed done pulses. Directed cases cover the one-channel scan, a flag left uncleared across passes, an abort followed by a restart into the other group, and trigger-started scans.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_BUSY  = 2'd2
    } scan_state_e;
endpackage

// File: rtl/scan_ctl.sv
module scan_ctl #(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          wr_run,
    input  logic          wr_grp,
    input  logic [IW-1:0] wr_cnt,
    input  logic          wr_ie,
    input  logic          trig,
    input  logic          flag_clr,
    input  logic          pass_end,
    output logic          run_q,
    output logic          grp_q,
    output logic [IW-1:0] cnt_q,
    output logic          ie_q,
    output logic          flag_q,
    output logic          irq
);
    // Control word: a write has priority over the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            grp_q <= 1'b0;
            cnt_q <= '0;
            ie_q  <= 1'b0;
        end else if (ctl_we) begin
            run_q <= wr_run;
            grp_q <= wr_grp;
            cnt_q <= wr_cnt;
            ie_q  <= wr_ie;
        end else if (trig) begin
            run_q <= 1'b1;
        end
    end

    // Sticky end-of-scan flag: a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (pass_end) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign irq = flag_q & ie_q;

    p_trig_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !ctl_we) |=> run_q);
    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pass_end |=> flag_q);
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_q,
    input  logic [IW-1:0] cnt_q,
    input  logic          conv_done,
    output logic [IW-1:0] idx,
    output logic          conv_start,
    output logic          accept,
    output logic          pass_end
);
    scan_state_e state, nxt;

    // State register and pass position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) idx <= '0;
            else if (accept)      idx <= pass_end ? '0 : idx + IW'(1);
        end
    end

    // Transitions.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = run_q ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: nxt = run_q ? ST_BUSY : ST_IDLE;
            ST_BUSY: begin
                if (!run_q)         nxt = ST_IDLE;
                else if (conv_done) nxt = ST_ISSUE;
                else                nxt = ST_BUSY;
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        conv_start = (state == ST_ISSUE);
        accept     = (state == ST_BUSY) && run_q && conv_done;
        pass_end   = accept && (idx == cnt_q);
    end

    p_gapless_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> conv_start);
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    p_fresh_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !$past(conv_done)) |-> (idx == '0));
    p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> !conv_start);
endmodule

// File: rtl/scan_res.sv
module scan_res #(
    parameter int DW    = 10,
    parameter int SLOTS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(SLOTS)-1:0] slot,
    input  logic [DW-1:0]            din,
    output logic [SLOTS*DW-1:0]      res_flat
);
    localparam int IW = $clog2(SLOTS);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [DW-1:0] r;
        always_ff @(posedge clk) begin
            if (!rst_n)                       r <= '0;
            else if (we && slot == IW'(k))    r <= din;
        end
        assign res_flat[k*DW +: DW] = r;
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(res_flat));
endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
    parameter int DW    = 10,
    parameter int SLOTS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_we,
    input  logic                     wr_run,
    input  logic                     wr_grp,
    input  logic [$clog2(SLOTS)-1:0] wr_cnt,
    input  logic                     wr_ie,
    input  logic                     flag_clr,
    input  logic                     trig,
    input  logic                     conv_done,
    input  logic [DW-1:0]            conv_data,
    output logic                     conv_start,
    output logic [$clog2(SLOTS):0]   conv_chan,
    output logic                     scan_run,
    output logic                     eos_flag,
    output logic                     irq,
    output logic [SLOTS*DW-1:0]      res_flat
);
    localparam int IW = $clog2(SLOTS);

    logic          run_q, grp_q, ie_q, accept, pass_end;
    logic [IW-1:0] cnt_q, idx;

    scan_ctl #(.IW(IW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .wr_run(wr_run),
        .wr_grp(wr_grp), .wr_cnt(wr_cnt), .wr_ie(wr_ie), .trig(trig),
        .flag_clr(flag_clr), .pass_end(pass_end), .run_q(run_q),
        .grp_q(grp_q), .cnt_q(cnt_q), .ie_q(ie_q), .flag_q(eos_flag),
        .irq(irq)
    );

    scan_fsm #(.IW(IW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run_q(run_q), .cnt_q(cnt_q),
        .conv_done(conv_done), .idx(idx), .conv_start(conv_start),
        .accept(accept), .pass_end(pass_end)
    );

    scan_res #(.DW(DW), .SLOTS(SLOTS)) u_res (
        .clk(clk), .rst_n(rst_n), .we(accept), .slot(idx),
        .din(conv_data), .res_flat(res_flat)
    );

    assign conv_chan = {grp_q, idx};
    assign scan_run  = run_q;

    p_no_irq_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq);
endmodule

// File: tb/sim_scan_seq.sv
module sim_scan_seq;
    localparam int DW = 10;
    localparam int SLOTS = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, ctl_we = 0, wr_run = 0, wr_grp = 0, wr_ie = 0;
    logic flag_clr = 0, trig = 0, conv_done = 0;
    logic [1:0] wr_cnt = '0;
    logic [DW-1:0] conv_data = '0;
    logic conv_start, scan_run, eos_flag, irq;
    logic [2:0] conv_chan;
    logic [SLOTS*DW-1:0] res_flat;

    scan_seq #(.DW(DW), .SLOTS(SLOTS)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .wr_run(wr_run),
        .wr_grp(wr_grp), .wr_cnt(wr_cnt), .wr_ie(wr_ie), .flag_clr(flag_clr),
        .trig(trig), .conv_done(conv_done), .conv_data(conv_data),
        .conv_start(conv_start), .conv_chan(conv_chan), .scan_run(scan_run),
        .eos_flag(eos_flag), .irq(irq), .res_flat(res_flat)
    );

    int n_chk = 0, n_err = 0;
    bit mdl_flag = 0;
    bit reported = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_chan(input bit g, input int pos);
        return g * 4 + pos;
    endfunction

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_ctl(input bit run, input bit g, input logic [1:0] c, input bit ie);
        ctl_we = 1; wr_run = run; wr_grp = g; wr_cnt = c; wr_ie = ie;
        tick();
        ctl_we = 0;
    endtask

    // Starts a scan; returns at the negedge where the first conv_start shows.
    task automatic start_scan(input bit g, input logic [1:0] c, input bit ie, input bit use_trig);
        if (use_trig) begin
            write_ctl(0, g, c, ie);
            trig = 1;
            tick();
            trig = 0;
        end else begin
            write_ctl(1, g, c, ie);
        end
        chk(scan_run == 1, "R2", scan_run, 1);
        chk(conv_start == 0, "R2", conv_start, 0);
        tick();
        chk(conv_start == 1, "R2", conv_start, 1);
    endtask

    // One conversion, entered at a negedge where conv_start is high.
    task automatic one_conv(input bit g, input logic [1:0] c, input bit ie,
                            inout int pos, input bit clr);
        int lat;
        logic [DW-1:0] d;
        bit last;
        chk(int'(conv_chan) == exp_chan(g, pos), (pos == 0) ? "R3" : "R4",
            int'(conv_chan), exp_chan(g, pos));
        flag_clr = clr;
        tick();
        flag_clr = 0;
        if (clr) mdl_flag = 0;
        chk(conv_start == 0, "R5", conv_start, 0);
        chk(eos_flag == mdl_flag, "R8", eos_flag, mdl_flag);
        lat = int'($urandom_range(0, 3));
        for (int i = 0; i < lat; i++) begin
            tick();
            chk(conv_start == 0, "R5", conv_start, 0);
        end
        d = DW'($urandom);
        conv_done = 1; conv_data = d;
        tick();
        conv_done = 0;
        last = (pos == int'(c));
        if (last) mdl_flag = 1;
        chk(res_flat[pos*DW +: DW] == d, "R6", int'(res_flat[pos*DW +: DW]), int'(d));
        chk(conv_start == 1, "R5", conv_start, 1);
        chk(eos_flag == mdl_flag, last ? "R7" : "R8", eos_flag, mdl_flag);
        chk(irq == (mdl_flag & ie), "R9", irq, mdl_flag & ie);
        pos = last ? 0 : pos + 1;
    endtask

    // Stops from a conv_start negedge, then clears the flag.
    task automatic stop_scan(input bit g, input logic [1:0] c, input bit ie);
        write_ctl(0, g, c, ie);
        chk(scan_run == 0, "R10", scan_run, 0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(conv_start == 0, "R10", conv_start, 0);
        end
        flag_clr = 1;
        tick();
        flag_clr = 0;
        mdl_flag = 0;
        chk(eos_flag == 0, "R8", eos_flag, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not finish actual=hang expected=done");
        report();
    end

    initial begin
        int pos;
        logic [SLOTS*DW-1:0] snap;
        bit snap_flag;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk(conv_start == 0, "R1", conv_start, 0);
        chk(scan_run == 0, "R1", scan_run, 0);
        chk(eos_flag == 0 && irq == 0, "R1", eos_flag, 0);
        chk(res_flat == '0, "R1", int'(res_flat[DW-1:0]), 0);

        // Three channels, flag left set across passes (R7, R8)
        start_scan(0, 2'b10, 1, 0);
        pos = 0;
        for (int k = 0; k < 7; k++) one_conv(0, 2'b10, 1, pos, 0);
        stop_scan(0, 2'b10, 1);

        // One channel in group 1, trigger start, flag cleared each time (R7, R2)
        start_scan(1, 2'b00, 0, 1);
        pos = 0;
        for (int k = 0; k < 4; k++) one_conv(1, 2'b00, 0, pos, k > 0);
        stop_scan(1, 2'b00, 0);

        // Abort mid-conversion, restart into the other group (R10, R11)
        start_scan(0, 2'b11, 1, 0);
        pos = 0;
        one_conv(0, 2'b11, 1, pos, 0);
        one_conv(0, 2'b11, 1, pos, 0);
        tick();
        write_ctl(0, 0, 2'b11, 1);
        snap = res_flat; snap_flag = eos_flag;
        conv_done = 1; conv_data = DW'(10'h2AA);
        tick();
        conv_done = 0;
        chk(res_flat == snap, "R10", int'(res_flat[2*DW +: DW]), int'(snap[2*DW +: DW]));
        chk(eos_flag == snap_flag, "R10", eos_flag, snap_flag);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(conv_start == 0, "R10", conv_start, 0);
        end
        start_scan(1, 2'b01, 1, 0);
        chk(int'(conv_chan) == 4, "R11", int'(conv_chan), 4);
        pos = 0;
        for (int k = 0; k < 5; k++) one_conv(1, 2'b01, 1, pos, 0);
        stop_scan(1, 2'b01, 1);

        // Constrained random scans
        for (int s = 0; s < 10; s++) begin
            bit g, ie, tr;
            logic [1:0] c;
            int n;
            g = 1'($urandom); ie = 1'($urandom); tr = 1'($urandom);
            c = 2'($urandom);
            n = (int'(c) + 1) * 2 + int'($urandom_range(0, 3));
            start_scan(g, c, ie, tr);
            chk(int'(conv_chan) == exp_chan(g, 0), "R11", int'(conv_chan), exp_chan(g, 0));
            pos = 0;
            for (int k = 0; k < n; k++) one_conv(g, c, ie, pos, 1'($urandom));
            stop_scan(g, c, ie);
        end
        report();
    end
endmodule